// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and an incoming carry. It returns a 16-bit sum and the carry out of the top bit. It is purely combinational and has no clock, state or reset.

The operands are split into four slices of four bits each. Each slice forms two terms for every bit: a bit *generate*, which is the AND of the two operand bits, and a bit *propagate*, which is the OR of the two operand bits. Each slice derives its inner carries as flat sums of products, so no carry ripples inside a slice. Each slice also reports a slice-generate and a slice-propagate term.

A second lookahead stage takes those slice terms and the incoming carry. It produces the carry into every slice and the final carry-out, again as flat sums of products, so no carry ripples between slices either. Each sum bit is the XOR of the two operand bits and the carry into that bit. The OR-based propagate cannot stand in for that XOR.

The block has no states and no transitions. Its single mode of operation is the combinational path from operands to outputs.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + c_in`, with all values treated as unsigned.
- R2: `c_out` equals bit 16 of `a_in + b_in + c_in`.
- R3: The carry into slice k (bit 4k, for k = 1, 2, 3) equals the carry out of the unsigned sum of the low 4k bits of both operands plus `c_in`. At the ports this shows as `sum_out[4k]` being `a_in[4k] ^ b_in[4k] ^ carry`.
- R4: A carry produced in the lowest slice reaches `c_out` when every higher bit position has at least one operand bit set. For example, 0xFFF8 + 0x0008 + 0 gives sum 0x0000 and `c_out` = 1.
- R5: `c_in` alone travels through all sixteen positions when each position has exactly one operand bit set. For example, 0x5555 + 0xAAAA + 1 gives 0x0000 and carry 1, and the same operands with `c_in` = 0 give 0xFFFF and carry 0.
- R6: A slice in which every bit has both operand bits set produces a carry out of that slice whatever the carry into it. For example, 0x0F00 + 0x0F00 gives 0x1E00 and `c_out` = 0, and 0xF000 + 0xF000 + 1 gives 0xE001 and `c_out` = 1.
- R7: The outputs hold no state. They settle to the value for the present inputs within the same time step as an input change, and when all inputs are zero both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Incoming carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |

## Verification
The two functions that meet in one evaluation are a slice's own generate and a carry arriving into that slice from the second lookahead stage. Both can be true for the same slice at once, and the slice's carry out must then still be a single 1.

Directed operands provoke this overlap. Examples are fully set slices sitting above a propagating chain, and 0xFFFF + 0xFFFF + 1. Several thousand random operand pairs, drawn from a fixed seed, are mixed in with these directed cases.

Each result is judged against an unsigned reference sum computed in the bench. The check covers the full sum, the top carry and the sum bit at each slice boundary.

// File: rtl/cla16_pkg.sv
package cla16_pkg;
    localparam int unsigned CLA_DEF_WIDTH = 16;
    localparam int unsigned CLA_DEF_SLICE = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } cla_gp_t;
endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] half_o
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign gen_o[gi]  = a_i[gi] & b_i[gi];
            assign prop_o[gi] = a_i[gi] | b_i[gi];
            assign half_o[gi] = a_i[gi] ^ b_i[gi];
        end
    endgenerate
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla16_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-1:0] cin_pos_o,
    output logic         cout_o,
    output cla_gp_t      grp_o
);
    logic [N-1:0] cout_v;
    logic         grp_gen;
    logic         grp_prop;

    // Flat sum-of-products carries: each output carry is an OR of AND terms.
    always_comb begin
        logic acc;
        logic term;
        cout_v = '0;
        for (int i = 0; i < N; i++) begin
            acc = 1'b0;
            for (int j = -1; j <= i; j++) begin
                term = (j < 0) ? cin_i : gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_i[k];
                end
                acc = acc | term;
            end
            cout_v[i] = acc;
        end
    end

    // Group generate excludes the incoming carry term.
    always_comb begin
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen_i[j];
            for (int k = j + 1; k < N; k++) begin
                term = term & prop_i[k];
            end
            acc = acc | term;
        end
        grp_gen  = acc;
        grp_prop = &prop_i;
    end

    always_comb begin
        cin_pos_o[0] = cin_i;
        for (int i = 1; i < N; i++) begin
            cin_pos_o[i] = cout_v[i-1];
        end
    end

    assign cout_o        = cout_v[N-1];
    assign grp_o.gen     = grp_gen;
    assign grp_o.prop    = grp_prop;
endmodule

// File: rtl/cla_sum_stage.sv
module cla_sum_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] half_i,
    input  logic [WIDTH-1:0] carry_i,
    output logic [WIDTH-1:0] sum_o
);
    genvar si;
    generate
        for (si = 0; si < WIDTH; si++) begin : g_sum
            assign sum_o[si] = half_i[si] ^ carry_i[si];
        end
    endgenerate
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla16_pkg::*;
#(
    parameter int unsigned WIDTH = CLA_DEF_WIDTH,
    parameter int unsigned SLICE = CLA_DEF_SLICE
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);
    localparam int unsigned NSLICE = WIDTH / SLICE;

    logic [WIDTH-1:0]  bit_gen;
    logic [WIDTH-1:0]  bit_prop;
    logic [WIDTH-1:0]  bit_half;
    logic [WIDTH-1:0]  bit_carry;
    logic [NSLICE-1:0] grp_gen;
    logic [NSLICE-1:0] grp_prop;
    logic [NSLICE-1:0] grp_carry;
    logic [NSLICE-1:0] slice_cout;
    cla_gp_t           top_gp;

    cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .a_i    (a_in),
        .b_i    (b_in),
        .gen_o  (bit_gen),
        .prop_o (bit_prop),
        .half_o (bit_half)
    );

    genvar gs;
    generate
        for (gs = 0; gs < NSLICE; gs++) begin : g_slice
            cla_gp_t slice_gp;
            cla_lookahead #(.N(SLICE)) u_slice (
                .gen_i     (bit_gen[gs*SLICE +: SLICE]),
                .prop_i    (bit_prop[gs*SLICE +: SLICE]),
                .cin_i     (grp_carry[gs]),
                .cin_pos_o (bit_carry[gs*SLICE +: SLICE]),
                .cout_o    (slice_cout[gs]),
                .grp_o     (slice_gp)
            );
            assign grp_gen[gs]  = slice_gp.gen;
            assign grp_prop[gs] = slice_gp.prop;
        end
    endgenerate

    cla_lookahead #(.N(NSLICE)) u_upper (
        .gen_i     (grp_gen),
        .prop_i    (grp_prop),
        .cin_i     (c_in),
        .cin_pos_o (grp_carry),
        .cout_o    (c_out),
        .grp_o     (top_gp)
    );

    cla_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .half_i  (bit_half),
        .carry_i (bit_carry),
        .sum_o   (sum_out)
    );
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned SLICE = 4
) (
    input logic [WIDTH-1:0]       a_in,
    input logic [WIDTH-1:0]       b_in,
    input logic                   c_in,
    input logic [WIDTH-1:0]       sum_out,
    input logic                   c_out,
    input logic [WIDTH/SLICE-1:0] grp_gen,
    input logic [WIDTH/SLICE-1:0] grp_prop,
    input logic [WIDTH/SLICE-1:0] grp_carry
);
    localparam int unsigned NSLICE = WIDTH / SLICE;

    logic known;
    assign known = !$isunknown({a_in, b_in, c_in});

    always_comb begin
        logic [WIDTH:0] full;
        full = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
        if (known) begin
            p_sum_r1: assert (sum_out == full[WIDTH-1:0]);
            p_cout_r2: assert (c_out == full[WIDTH]);
        end
    end

    always_comb begin
        logic [WIDTH:0] part;
        logic [SLICE:0] sl;
        if (known) begin
            for (int k = 1; k < NSLICE; k++) begin
                part = '0;
                for (int b = 0; b < k * SLICE; b++) begin
                    part[b] = 1'b1;
                end
                part = ({1'b0, a_in} & part) + ({1'b0, b_in} & part) + {{WIDTH{1'b0}}, c_in};
                p_grp_carry_r3: assert (grp_carry[k] == part[k*SLICE]);
            end
            for (int k = 0; k < NSLICE; k++) begin
                sl = {1'b0, a_in[k*SLICE +: SLICE]} + {1'b0, b_in[k*SLICE +: SLICE]};
                // slice generate means a carry with no carry in
                p_gen_r6: assert (!grp_gen[k] || sl[SLICE]);
                sl = sl + 1'b1;
                // slice propagate means a carry whenever a carry enters
                p_prop_r5: assert (!grp_prop[k] || sl[SLICE]);
            end
        end
    end
endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .c_in      (c_in),
    .sum_out   (sum_out),
    .c_out     (c_out),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .grp_carry (grp_carry)
);

// File: tb/tb_cla16_adder.sv
`timescale 1ns/1ps
module tb_cla16_adder;
    logic        clk = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        c_in = 1'b0;
    logic [15:0] sum_out;
    logic        c_out;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cla16_adder dut (
        .a_in    (a_in),
        .b_in    (b_in),
        .c_in    (c_in),
        .sum_out (sum_out),
        .c_out   (c_out)
    );

    function automatic logic [16:0] ref_add(logic [15:0] a, logic [15:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    function automatic logic ref_slice_carry(logic [15:0] a, logic [15:0] b, logic c, int k);
        logic [16:0] m;
        logic [16:0] s;
        m = (17'd1 << (4 * k)) - 17'd1;
        s = ({1'b0, a} & m) + ({1'b0, b} & m) + {16'd0, c};
        return s[4 * k];
    endfunction

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] e;
        @(negedge clk);
        a_in = a;
        b_in = b;
        c_in = c;
        #1;
        e = ref_add(a, b, c);
        check("R1", {1'b0, sum_out}, {1'b0, e[15:0]});
        check("R2", {16'd0, c_out}, {16'd0, e[16]});
        for (int k = 1; k < 4; k++) begin
            check("R3", {16'd0, sum_out[4*k]},
                  {16'd0, a[4*k] ^ b[4*k] ^ ref_slice_carry(a, b, c, k)});
        end
    endtask

    initial begin
        #1;
        check("R7", {c_out, sum_out}, 17'd0);
        apply(16'hFFF8, 16'h0008, 1'b0);
        check("R4", {c_out, sum_out}, {1'b1, 16'h0000});
        apply(16'h5555, 16'hAAAA, 1'b1);
        check("R5", {c_out, sum_out}, {1'b1, 16'h0000});
        apply(16'h5555, 16'hAAAA, 1'b0);
        check("R5", {c_out, sum_out}, {1'b0, 16'hFFFF});
        apply(16'h0F00, 16'h0F00, 1'b0);
        check("R6", {c_out, sum_out}, {1'b0, 16'h1E00});
        apply(16'hF000, 16'hF000, 1'b1);
        check("R6", {c_out, sum_out}, {1'b1, 16'hE001});
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        check("R6", {c_out, sum_out}, {1'b1, 16'hFFFF});
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R3", {c_out, sum_out}, {1'b1, 16'h0000});
        apply(16'h0FFF, 16'h0001, 1'b0);
        check("R3", {c_out, sum_out}, {1'b0, 16'h1000});
        // R7: input change settles in the same time step, no clock edge needed
        a_in = 16'h1234;
        b_in = 16'h4321;
        c_in = 1'b1;
        #0.1;
        check("R7", {c_out, sum_out}, ref_add(16'h1234, 16'h4321, 1'b1));
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 5 == 0) rb = ~ra;
            if (n % 7 == 0) ra = ra | 16'hF0F0;
            apply(ra, rb, 1'($urandom));
        end
        apply(16'h0000, 16'h0000, 1'b0);
        check("R7", {c_out, sum_out}, 17'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule